// File: doc/BRIEF.md
# Reset Cause Controller

This block merges five reset requests into one active-low reset output and records, in a sticky status register, which of them caused the most recent reset. The five are supply power-on, low supply voltage, watchdog, over-temperature and an external reset pin. Voltage and temperature detection happen elsewhere. Here they arrive as synchronous, active-high digital request lines, and the external pin arrives as a synchronous active-low level. Every request stretches the reset output by a fixed number of clock cycles after it goes away. A registered clear strobe is driven to a bank of control registers outside the block.

Reset domains are selective. A power-on request wipes everything, including the status register. The other four sources clear the configuration register but leave the status register alone, apart from setting their own flag. Two wake-up flags share the status register with the cause flags. One records bus activity and one records the dedicated wake pin.

Software uses a one-bit select, a write strobe, write data and combinational read data. Select 0 is the status register, whose flags are cleared by writing ones. Select 1 is the configuration register. Its bit 0 blocks the over-temperature request.

Top module: `reset_cause_unit`

## Requirements
- R1: A power-on event clears the configuration register to 0, sets the status register to exactly 0x01 (bit 0 only) and drives `rst_out_n` low. A power-on event is either `rst_n` held low or `supply_ok` low at a clock edge.
- R2: A low-voltage request (`lvd_req`), a watchdog request (`wdog_req`) or an unmasked over-temperature request (`ovt_req`) sets status bit 1, 2 or 3 respectively. The other status bits are left as they were, and the configuration register is cleared to 0.
- R3: `ext_rst_n` low at a clock edge sets status bit 4 and drives `rst_out_n` low.
- R4: While configuration bit 0 is 1, `ovt_req` has no effect. It causes no reset, no `ctl_clr` and no change to status bit 3.
- R5: A write with `reg_sel`=0 clears every status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R6: A status flag stays set until it is cleared by a write or by a power-on event.
- R7: `rst_out_n` is low in the cycle after any edge with an effective request. It returns high at the PULSE_CYC-th rising edge after the last edge at which a request was sampled. A new request restarts this count.
- R8: When several non-power-on requests arrive at the same edge, each one sets its own flag. A power-on request at the same edge overrides them and leaves the status at exactly 0x01.
- R9: When a flag is written with 1 at the same edge that its event occurs, the flag stays set.
- R10: `wake_bus_evt` sets status bit 5 and `wake_pin_evt` sets status bit 6. Both are cleared by writing ones, and neither causes a reset.
- R11: `ctl_clr` is high in the cycle after each edge with an effective request and low in the cycle after each edge without one.
- R12: A write with `reg_sel`=1 loads configuration bit 0 from `reg_wdata[0]`, and the register reads back on `reg_rdata[0]`. The write is ignored at an edge where an effective request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously |
| supply_ok | input | 1 | Supply good. Low means a power-on request |
| lvd_req | input | 1 | Low-voltage reset request |
| wdog_req | input | 1 | Watchdog reset request |
| ovt_req | input | 1 | Over-temperature reset request |
| ext_rst_n | input | 1 | External reset pin level, active low |
| wake_bus_evt | input | 1 | Single-cycle wake event from bus activity |
| wake_pin_evt | input | 1 | Single-cycle wake event from the wake pin |
| reg_sel | input | 1 | Register select: 0 status, 1 configuration |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 7 | Write data |
| reg_rdata | output | 7 | Read data for the selected register |
| rst_out_n | output | 1 | Stretched active-low reset output |
| ctl_clr | output | 1 | Clear strobe for external control registers |

## Verification
A software write that clears flags can land on the same edge as a hardware event that sets one of those flags. The bench provokes this by raising `lvd_req` during a write of 0x03 to the status register. The expected result is 0x02: the POR bit is cleared because it had no competing event, and the LVR bit is held set by its event. A second collision is a configuration write issued while a request is active. That write must be lost, and the bench judges this by reading the configuration register back once the request has ended.

// File: rtl/rcu_pkg.sv
package rcu_pkg;
  localparam int FLAG_W  = 7;
  localparam int F_POR   = 0;
  localparam int F_LVR   = 1;
  localparam int F_WDR   = 2;
  localparam int F_HTR   = 3;
  localparam int F_PINR  = 4;
  localparam int F_WBUS  = 5;
  localparam int F_WPIN  = 6;
  localparam int CFG_W   = 1;
  localparam int CFG_OVT_DIS = 0;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CFG    = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic pin;
    logic ovt;
    logic wdog;
    logic lvd;
    logic por;
  } req_t;
endpackage

// File: rtl/rcu_rst_sync.sv
module rcu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rcu_req_gate.sv
module rcu_req_gate
  import rcu_pkg::*;
(
  input  logic supply_ok,
  input  logic lvd_req,
  input  logic wdog_req,
  input  logic ovt_req,
  input  logic ext_rst_n,
  input  logic ovt_dis,
  output req_t req,
  output logic any_req
);
  always_comb begin
    req.por  = !supply_ok;
    req.lvd  = lvd_req;
    req.wdog = wdog_req;
    req.ovt  = ovt_req && !ovt_dis;
    req.pin  = !ext_rst_n;
    any_req  = |req;
  end
endmodule

// File: rtl/rcu_stretch.sv
module rcu_stretch #(
  parameter int PULSE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_req,
  output logic rst_out_n
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = any_req || (cnt_q != '0);
    if (any_req) begin
      cnt_d = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
    out_d = !any_req && (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_LOAD;
      out_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign rst_out_n = out_q;
endmodule

// File: rtl/rcu_status.sv
module rcu_status
  import rcu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  req_t              req,
  input  logic              wake_bus,
  input  logic              wake_pin,
  input  logic [FLAG_W-1:0] clr_bits,
  output logic [FLAG_W-1:0] status
);
  localparam logic [FLAG_W-1:0] POR_ONLY = FLAG_W'(1) << F_POR;

  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] keep_d;
  logic [FLAG_W-1:0] status_q, status_d;
  logic              status_en;

  always_comb begin
    set_vec         = '0;
    set_vec[F_LVR]  = req.lvd;
    set_vec[F_WDR]  = req.wdog;
    set_vec[F_HTR]  = req.ovt;
    set_vec[F_PINR] = req.pin;
    set_vec[F_WBUS] = wake_bus;
    set_vec[F_WPIN] = wake_pin;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    assign keep_d[i] = (status_q[i] && !clr_bits[i]) || set_vec[i];
  end

  always_comb begin
    status_en = req.por || (|set_vec) || (|clr_bits);
    status_d  = req.por ? POR_ONLY : keep_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= POR_ONLY;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  assign status = status_q;
endmodule

// File: rtl/rcu_cfg_reg.sv
module rcu_cfg_reg #(
  parameter int CFG_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_req,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg
);
  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = any_req || wr_en;
    cfg_d  = any_req ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/reset_cause_unit.sv
module reset_cause_unit
  import rcu_pkg::*;
#(
  parameter int PULSE_CYC   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              lvd_req,
  input  logic              wdog_req,
  input  logic              ovt_req,
  input  logic              ext_rst_n,
  input  logic              wake_bus_evt,
  input  logic              wake_pin_evt,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [FLAG_W-1:0] reg_wdata,
  output logic [FLAG_W-1:0] reg_rdata,
  output logic              rst_out_n,
  output logic              ctl_clr
);
  logic              rst_sync_n;
  req_t              req;
  logic              any_req;
  logic [CFG_W-1:0]  cfg_q;
  logic [FLAG_W-1:0] status_q;
  logic [FLAG_W-1:0] clr_bits;
  logic              cfg_wr_en;
  logic              ctl_clr_q;

  rcu_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rcu_req_gate u_gate (
    .supply_ok (supply_ok),
    .lvd_req   (lvd_req),
    .wdog_req  (wdog_req),
    .ovt_req   (ovt_req),
    .ext_rst_n (ext_rst_n),
    .ovt_dis   (cfg_q[CFG_OVT_DIS]),
    .req       (req),
    .any_req   (any_req)
  );

  rcu_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .any_req   (any_req),
    .rst_out_n (rst_out_n)
  );

  always_comb begin
    clr_bits  = (reg_wr && (reg_sel == SEL_STATUS)) ? reg_wdata : '0;
    cfg_wr_en = reg_wr && (reg_sel == SEL_CFG) && !any_req;
  end

  rcu_status u_status (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .req      (req),
    .wake_bus (wake_bus_evt),
    .wake_pin (wake_pin_evt),
    .clr_bits (clr_bits),
    .status   (status_q)
  );

  rcu_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .any_req (any_req),
    .wr_en   (cfg_wr_en),
    .wdata   (reg_wdata[CFG_W-1:0]),
    .cfg     (cfg_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_clr_q <= 1'b1;
    end else begin
      ctl_clr_q <= any_req;
    end
  end

  assign ctl_clr   = ctl_clr_q;
  assign reg_rdata = (reg_sel == SEL_CFG) ? FLAG_W'(cfg_q) : status_q;
endmodule

// File: rtl/reset_cause_unit_chk.sv
module reset_cause_unit_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       supply_ok,
  input logic       lvd_req,
  input logic       wdog_req,
  input logic       ovt_req,
  input logic       ext_rst_n,
  input logic       any_req,
  input logic       ovt_dis,
  input logic       reg_wr,
  input logic       reg_sel,
  input logic [6:0] reg_wdata,
  input logic [6:0] status,
  input logic       rst_out_n,
  input logic       ctl_clr
);
  logic [6:0] clr;
  assign clr = (reg_wr && !reg_sel) ? reg_wdata : 7'h00;

  a_r7_low_while_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    any_req |=> !rst_out_n);

  a_r11_clr_on_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    any_req |=> ctl_clr);

  a_r11_clr_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !any_req |=> !ctl_clr);

  a_r1_por_only: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !supply_ok |=> (status == 7'h01));

  a_r9_lvr_set_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (supply_ok && lvd_req) |=> status[1]);

  a_r2_htr_sets: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (supply_ok && ovt_req && !ovt_dis) |=> status[3]);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    supply_ok |=> ((($past(status) & ~$past(clr)) & ~status) == 7'h00));

  a_r4_masked_ovt: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovt_dis && supply_ok && !lvd_req && !wdog_req && ext_rst_n) |=> !ctl_clr);
endmodule

bind reset_cause_unit reset_cause_unit_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .supply_ok  (supply_ok),
  .lvd_req    (lvd_req),
  .wdog_req   (wdog_req),
  .ovt_req    (ovt_req),
  .ext_rst_n  (ext_rst_n),
  .any_req    (any_req),
  .ovt_dis    (cfg_q[0]),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .status     (status_q),
  .rst_out_n  (rst_out_n),
  .ctl_clr    (ctl_clr)
);

// File: tb/reset_cause_unit_test.sv
module reset_cause_unit_test;
  localparam int P = 64;

  logic       clk = 1'b0;
  logic       rst_n, supply_ok, lvd_req, wdog_req, ovt_req, ext_rst_n;
  logic       wake_bus_evt, wake_pin_evt, reg_sel, reg_wr;
  logic [6:0] reg_wdata, reg_rdata;
  logic       rst_out_n, ctl_clr;
  int         checks = 0;
  int         fails  = 0;

  always #10 clk = ~clk;

  reset_cause_unit #(.PULSE_CYC(P)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .lvd_req(lvd_req),
    .wdog_req(wdog_req), .ovt_req(ovt_req), .ext_rst_n(ext_rst_n),
    .wake_bus_evt(wake_bus_evt), .wake_pin_evt(wake_pin_evt),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rst_out_n(rst_out_n), .ctl_clr(ctl_clr)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic sel, output logic [6:0] v);
    reg_sel = sel;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic sel, input logic [6:0] d);
    reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic settle();
    repeat (P + 2) tick();
  endtask

  task automatic t_reset();
    logic [6:0] v;
    rst_n = 1'b0;
    repeat (3) tick();
    rd(1'b0, v); chk("R1 status in reset", v, 7'h01);
    rd(1'b1, v); chk("R1 cfg in reset", v, 7'h00);
    chk("R1 rst_out_n in reset", rst_out_n, 1'b0);
    chk("R11 ctl_clr in reset", ctl_clr, 1'b1);
    rst_n = 1'b1;
    repeat (P + 4) tick();
    chk("R7 rst_out_n after power-on", rst_out_n, 1'b1);
    rd(1'b0, v); chk("R6 POR stays", v, 7'h01);
  endtask

  task automatic t_w1c();
    logic [6:0] v;
    wr(1'b0, 7'h00); rd(1'b0, v); chk("R5 write zero keeps", v, 7'h01);
    wr(1'b0, 7'h01); rd(1'b0, v); chk("R5 write one clears", v, 7'h00);
  endtask

  task automatic t_lvd_timing();
    logic [6:0] v;
    wr(1'b1, 7'h01); rd(1'b1, v); chk("R12 cfg write", v, 7'h01);
    lvd_req = 1'b1; tick(); lvd_req = 1'b0;
    chk("R7 low after lvd", rst_out_n, 1'b0);
    chk("R11 ctl_clr after lvd", ctl_clr, 1'b1);
    rd(1'b0, v); chk("R2 LVR set", v, 7'h02);
    rd(1'b1, v); chk("R2 cfg cleared by lvd", v, 7'h00);
    repeat (P - 1) tick();
    chk("R7 still low at P-1", rst_out_n, 1'b0);
    chk("R11 ctl_clr idle", ctl_clr, 1'b0);
    tick();
    chk("R7 high at P", rst_out_n, 1'b1);
  endtask

  task automatic t_wdog();
    logic [6:0] v;
    wdog_req = 1'b1; tick(); wdog_req = 1'b0;
    rd(1'b0, v); chk("R2 WDR set, LVR kept", v, 7'h06);
    settle();
    rd(1'b0, v); chk("R6 flags sticky", v, 7'h06);
  endtask

  task automatic t_ovt();
    logic [6:0] v;
    wr(1'b1, 7'h01);
    ovt_req = 1'b1; tick(); ovt_req = 1'b0;
    chk("R4 masked ovt no reset", rst_out_n, 1'b1);
    chk("R4 masked ovt no ctl_clr", ctl_clr, 1'b0);
    rd(1'b0, v); chk("R4 masked ovt no flag", v, 7'h06);
    wr(1'b1, 7'h00);
    ovt_req = 1'b1; tick(); ovt_req = 1'b0;
    chk("R2 ovt reset", rst_out_n, 1'b0);
    rd(1'b0, v); chk("R2 HTR set", v, 7'h0E);
    settle();
  endtask

  task automatic t_pin();
    logic [6:0] v;
    ext_rst_n = 1'b0; repeat (3) tick(); ext_rst_n = 1'b1;
    rd(1'b0, v); chk("R3 PINR set", v, 7'h1E);
    chk("R3 pin reset low", rst_out_n, 1'b0);
    repeat (P - 1) tick();
    chk("R7 restart low at P-1", rst_out_n, 1'b0);
    tick();
    chk("R7 restart high at P", rst_out_n, 1'b1);
  endtask

  task automatic t_simul();
    logic [6:0] v;
    wr(1'b0, 7'h7F); rd(1'b0, v); chk("R5 clear all", v, 7'h00);
    lvd_req = 1'b1; wdog_req = 1'b1; ext_rst_n = 1'b0; tick();
    lvd_req = 1'b0; wdog_req = 1'b0; ext_rst_n = 1'b1;
    rd(1'b0, v); chk("R8 each flag set", v, 7'h16);
    settle();
    wr(1'b1, 7'h01);
    supply_ok = 1'b0; lvd_req = 1'b1; wdog_req = 1'b1; tick();
    supply_ok = 1'b1; lvd_req = 1'b0; wdog_req = 1'b0;
    rd(1'b0, v); chk("R8 power-on overrides", v, 7'h01);
    rd(1'b1, v); chk("R1 cfg cleared by power-on", v, 7'h00);
    chk("R1 power-on reset low", rst_out_n, 1'b0);
    settle();
  endtask

  task automatic t_set_wins();
    logic [6:0] v;
    lvd_req = 1'b1; wr(1'b0, 7'h03); lvd_req = 1'b0;
    rd(1'b0, v); chk("R9 set beats clear", v, 7'h02);
    settle();
  endtask

  task automatic t_wake();
    logic [6:0] v;
    wake_bus_evt = 1'b1; tick(); wake_bus_evt = 1'b0;
    rd(1'b0, v); chk("R10 bus wake flag", v, 7'h22);
    wake_pin_evt = 1'b1; tick(); wake_pin_evt = 1'b0;
    rd(1'b0, v); chk("R10 pin wake flag", v, 7'h62);
    chk("R10 wake no reset", rst_out_n, 1'b1);
    wr(1'b0, 7'h20); rd(1'b0, v); chk("R10 clear bus wake", v, 7'h42);
  endtask

  task automatic t_cfg_ignored();
    logic [6:0] v;
    lvd_req = 1'b1; wr(1'b1, 7'h01); lvd_req = 1'b0;
    settle();
    rd(1'b1, v); chk("R12 write during request ignored", v, 7'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b1; lvd_req = 1'b0; wdog_req = 1'b0;
    ovt_req = 1'b0; ext_rst_n = 1'b1; wake_bus_evt = 1'b0; wake_pin_evt = 1'b0;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    @(negedge clk);
    t_reset();
    t_w1c();
    t_lvd_timing();
    t_wdog();
    t_ovt();
    t_pin();
    t_simul();
    t_set_wins();
    t_wake();
    t_cfg_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule